// File: doc/BRIEF.md
# Exception Entry Sequencer

This block steers a small processor core into its exception handlers. There are three ways in. The first is a reset, which starts when the core reset input is released. The second is an external interrupt, either the non-maskable one or a numbered maskable one. The third is a trap raised by an instruction.

For a reset, the block reads one word from the vector table at address 0. It hands that word back as the new program counter.

For an interrupt or a trap, the block first saves the interrupted context on the stack. It takes the current stack pointer and writes two 32-bit words below it. The first word holds the program counter. The second holds the condition code byte, placed in the upper byte of the word. The block then raises the interrupt mask bits and fetches the handler address from the vector table.

All memory traffic goes through one request port. A request is a plain address, write data and write enable, and the block waits for a ready answer on every access. When the entry is complete, the block gives one done pulse. It presents the new program counter, the new condition code byte and the new stack pointer on that pulse and keeps them until the next entry.

Requests are single-cycle pulses. They are taken only while the block is idle and interrupts are not blocked. Interrupts are blocked while the core is in reset, for the whole reset sequence, and for one cycle after that sequence ends.

Top module: `exc_entry_seq`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `mem_req` is 0. At the same time `done` is 0, `busy` is 1, `int_block` is 1, and `new_pc`, `new_ccr` and `new_sp` are all 0.
- R2: `cpu_reset_n` low at a clock edge ends any sequence in progress, whatever its state. From the next cycle `mem_req` and `done` stay 0, and `busy` and `int_block` stay 1, for as long as `cpu_reset_n` stays low.
- R3: A reset sequence starts only on the first edge at which `cpu_reset_n` is high after having been low. Leaving `rst` counts as a previous low. The sequence does one read at address 0. When it ends, `done` pulses, `new_pc` equals the word read and `new_ccr` equals 8'hC0 (both mask bits set).
- R4: `int_block` is 1 while the core is in reset and for the whole reset sequence. It stays 1 for exactly one more cycle after the reset `done` pulse. Any request that arrives while `int_block` is 1 is dropped: it starts no memory access and leaves `busy` at 0 afterwards.
- R5: Entry for an interrupt or a trap first writes `cur_pc` to address SP-4. It then writes {`cur_ccr`, 24'h0} to address SP-8, with SP taken from `cur_sp`. At `done`, `new_sp` equals SP-8. The values of SP, PC and CCR are taken in the cycle the request is accepted.
- R6: On interrupt or trap entry, the new CCR is the saved CCR with bit 7 (the I mask) set. If `user_en` was 0 at acceptance, bit 6 (the UI mask) is also set. All other bits are unchanged.
- R7: The vector read address is the exception number times 4. The non-maskable interrupt uses number 7. A trap with index k uses number 8+k. A maskable interrupt uses `irq_num`. `new_pc` is the word read at that address.
- R8: When several requests arrive in the same cycle, the non-maskable interrupt wins over a trap, and a trap wins over a maskable interrupt.
- R9: While `mem_req` is 1 and `mem_ready` is 0, the address, write data and write enable stay unchanged into the next cycle. The block moves to its next access only on `mem_ready`.
- R10: `done` lasts one cycle. Requests that arrive while `busy` is 1 are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high block reset |
| cpu_reset_n | input | 1 | Core reset, low holds the core in reset; release starts the reset sequence |
| user_en | input | 1 | Selects whether only I (1) or both I and UI (0) are set on entry |
| nmi_req | input | 1 | Non-maskable interrupt request pulse |
| trap_req | input | 1 | Trap request pulse |
| trap_idx | input | 2 | Trap index, selects vector 8 to 11 |
| irq_req | input | 1 | Maskable interrupt request pulse |
| irq_num | input | 4 | Exception number of the maskable interrupt |
| cur_pc | input | WORD_W | Program counter to save |
| cur_ccr | input | 8 | Condition code byte to save |
| cur_sp | input | WORD_W | Stack pointer at entry |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 for a write, 0 for a read |
| mem_addr | output | WORD_W | Byte address of the access |
| mem_wdata | output | WORD_W | Write data |
| mem_rdata | input | WORD_W | Read data, valid with mem_ready |
| mem_ready | input | 1 | Access completes in this cycle |
| new_pc | output | WORD_W | Program counter loaded from the vector |
| new_ccr | output | 8 | Condition code byte after entry |
| new_sp | output | WORD_W | Stack pointer after the pushes |
| done | output | 1 | One-cycle strobe at the end of an entry |
| busy | output | 1 | Block is not idle |
| int_block | output | 1 | Interrupts are blocked |

## Verification
The assertions assume that `mem_ready` is only meaningful while `mem_req` is high. They also assume that read data is valid in the same cycle as `mem_ready`. Finally, they assume that the core reset may drop at any cycle, including in the middle of an access.

The memory model in the stimulus only answers a pending request, with a latency of zero to two cycles. It returns a read word that is a fixed function of the address. Requests are driven as one-cycle pulses, with a chosen share of them landing during busy and blocked windows. The core reset is pulled low at random points, so that aborted accesses are exercised under the same assumptions.

// File: rtl/exc_seq_pkg.sv
package exc_seq_pkg;

    localparam int CCR_W     = 8;
    localparam int VEC_W     = 4;
    localparam int TRAP_W    = 2;
    localparam int I_BIT     = 7;
    localparam int UI_BIT    = 6;
    localparam int NMI_NUM   = 7;
    localparam int TRAP_BASE = 8;

    localparam logic [CCR_W-1:0] RESET_CCR =
        CCR_W'((1 << I_BIT) | (1 << UI_BIT));

    typedef enum logic [2:0] {
        ST_HOLD,
        ST_IDLE,
        ST_PUSH_PC,
        ST_PUSH_CCR,
        ST_FETCH,
        ST_FIN,
        ST_POST
    } seq_state_e;

    typedef enum logic [1:0] {
        SRC_NONE,
        SRC_NMI,
        SRC_TRAP,
        SRC_IRQ
    } src_e;

    typedef struct packed {
        src_e             src;
        logic [VEC_W-1:0] num;
    } exc_pick_t;

    function automatic logic [CCR_W-1:0] entry_mask(
        input logic [CCR_W-1:0] ccr,
        input logic             ue
    );
        logic [CCR_W-1:0] r;
        r        = ccr;
        r[I_BIT] = 1'b1;
        if (!ue) begin
            r[UI_BIT] = 1'b1;
        end
        return r;
    endfunction

endpackage

// File: rtl/exc_arbiter.sv
module exc_arbiter
    import exc_seq_pkg::*;
(
    input  logic              nmi_req,
    input  logic              trap_req,
    input  logic [TRAP_W-1:0] trap_idx,
    input  logic              irq_req,
    input  logic [VEC_W-1:0]  irq_num,
    output logic              req_any,
    output exc_pick_t         pick
);

    always_comb begin
        pick.src = SRC_NONE;
        pick.num = '0;
        if (nmi_req) begin
            pick.src = SRC_NMI;
            pick.num = VEC_W'(NMI_NUM);
        end else if (trap_req) begin
            pick.src = SRC_TRAP;
            pick.num = VEC_W'(TRAP_BASE) + VEC_W'(trap_idx);
        end else if (irq_req) begin
            pick.src = SRC_IRQ;
            pick.num = irq_num;
        end
    end

    assign req_any = (pick.src != SRC_NONE);

endmodule

// File: rtl/exc_seq_fsm.sv
module exc_seq_fsm
    import exc_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       cpu_reset_n,
    input  logic       req_any,
    input  logic       mem_ready,
    output seq_state_e state,
    output logic       in_reset_seq,
    output logic       take,
    output logic       rst_start,
    output logic       fetch_done
);

    logic       rn_q;
    seq_state_e nxt;

    assign take       = cpu_reset_n && (state == ST_IDLE) && req_any;
    assign rst_start  = cpu_reset_n && (state == ST_HOLD) && !rn_q;
    assign fetch_done = cpu_reset_n && (state == ST_FETCH) && mem_ready;

    always_comb begin
        nxt = state;
        if (!cpu_reset_n) begin
            nxt = ST_HOLD;
        end else begin
            case (state)
                ST_HOLD:     if (!rn_q) nxt = ST_FETCH;
                ST_IDLE:     if (req_any) nxt = ST_PUSH_PC;
                ST_PUSH_PC:  if (mem_ready) nxt = ST_PUSH_CCR;
                ST_PUSH_CCR: if (mem_ready) nxt = ST_FETCH;
                ST_FETCH:    if (mem_ready) nxt = ST_FIN;
                ST_FIN:      nxt = in_reset_seq ? ST_POST : ST_IDLE;
                ST_POST:     nxt = ST_IDLE;
                default:     nxt = ST_HOLD;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state        <= ST_HOLD;
            rn_q         <= 1'b0;
            in_reset_seq <= 1'b0;
        end else begin
            state <= nxt;
            rn_q  <= cpu_reset_n;
            if (rst_start) begin
                in_reset_seq <= 1'b1;
            end else if (take) begin
                in_reset_seq <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/exc_context.sv
module exc_context
    import exc_seq_pkg::*;
#(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              take,
    input  logic              rst_start,
    input  logic              fetch_done,
    input  logic              in_reset_seq,
    input  exc_pick_t         pick,
    input  logic              user_en,
    input  logic [WORD_W-1:0] cur_pc,
    input  logic [CCR_W-1:0]  cur_ccr,
    input  logic [WORD_W-1:0] cur_sp,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic [WORD_W-1:0] lat_pc,
    output logic [CCR_W-1:0]  lat_ccr,
    output logic [WORD_W-1:0] lat_sp,
    output logic [VEC_W-1:0]  lat_num,
    output logic [WORD_W-1:0] new_pc,
    output logic [CCR_W-1:0]  new_ccr,
    output logic [WORD_W-1:0] new_sp
);

    localparam int BYTES = WORD_W / 8;

    logic lat_ue;

    always_ff @(posedge clk) begin
        if (rst) begin
            lat_pc  <= '0;
            lat_ccr <= '0;
            lat_sp  <= '0;
            lat_num <= '0;
            lat_ue  <= 1'b0;
        end else if (take) begin
            lat_pc  <= cur_pc;
            lat_ccr <= cur_ccr;
            lat_sp  <= cur_sp;
            lat_num <= pick.num;
            lat_ue  <= user_en;
        end else if (rst_start) begin
            lat_num <= '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            new_pc  <= '0;
            new_ccr <= '0;
            new_sp  <= '0;
        end else if (fetch_done) begin
            new_pc <= mem_rdata;
            if (in_reset_seq) begin
                new_ccr <= RESET_CCR;
            end else begin
                new_ccr <= entry_mask(lat_ccr, lat_ue);
                new_sp  <= lat_sp - WORD_W'(2 * BYTES);
            end
        end
    end

endmodule

// File: rtl/exc_bus_drv.sv
module exc_bus_drv
    import exc_seq_pkg::*;
#(
    parameter int WORD_W = 32
) (
    input  seq_state_e        state,
    input  logic [WORD_W-1:0] lat_pc,
    input  logic [CCR_W-1:0]  lat_ccr,
    input  logic [WORD_W-1:0] lat_sp,
    input  logic [VEC_W-1:0]  lat_num,
    output logic              mem_req,
    output logic              mem_we,
    output logic [WORD_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata
);

    localparam int BYTES = WORD_W / 8;
    localparam int SHIFT = $clog2(BYTES);

    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        case (state)
            ST_PUSH_PC: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = lat_sp - WORD_W'(BYTES);
                mem_wdata = lat_pc;
            end
            ST_PUSH_CCR: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = lat_sp - WORD_W'(2 * BYTES);
                mem_wdata = {lat_ccr, {(WORD_W-CCR_W){1'b0}}};
            end
            ST_FETCH: begin
                mem_req  = 1'b1;
                mem_addr = WORD_W'(lat_num) << SHIFT;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
    import exc_seq_pkg::*;
#(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_reset_n,
    input  logic              user_en,
    input  logic              nmi_req,
    input  logic              trap_req,
    input  logic [TRAP_W-1:0] trap_idx,
    input  logic              irq_req,
    input  logic [VEC_W-1:0]  irq_num,
    input  logic [WORD_W-1:0] cur_pc,
    input  logic [CCR_W-1:0]  cur_ccr,
    input  logic [WORD_W-1:0] cur_sp,
    output logic              mem_req,
    output logic              mem_we,
    output logic [WORD_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic [WORD_W-1:0] mem_rdata,
    input  logic              mem_ready,
    output logic [WORD_W-1:0] new_pc,
    output logic [CCR_W-1:0]  new_ccr,
    output logic [WORD_W-1:0] new_sp,
    output logic              done,
    output logic              busy,
    output logic              int_block
);

    seq_state_e        state;
    exc_pick_t         pick;
    logic              req_any, in_reset_seq, take, rst_start, fetch_done;
    logic [WORD_W-1:0] lat_pc, lat_sp;
    logic [CCR_W-1:0]  lat_ccr;
    logic [VEC_W-1:0]  lat_num;

    exc_arbiter u_arb (
        .nmi_req  (nmi_req),
        .trap_req (trap_req),
        .trap_idx (trap_idx),
        .irq_req  (irq_req),
        .irq_num  (irq_num),
        .req_any  (req_any),
        .pick     (pick)
    );

    exc_seq_fsm u_fsm (
        .clk          (clk),
        .rst          (rst),
        .cpu_reset_n  (cpu_reset_n),
        .req_any      (req_any),
        .mem_ready    (mem_ready),
        .state        (state),
        .in_reset_seq (in_reset_seq),
        .take         (take),
        .rst_start    (rst_start),
        .fetch_done   (fetch_done)
    );

    exc_context #(.WORD_W(WORD_W)) u_ctx (
        .clk          (clk),
        .rst          (rst),
        .take         (take),
        .rst_start    (rst_start),
        .fetch_done   (fetch_done),
        .in_reset_seq (in_reset_seq),
        .pick         (pick),
        .user_en      (user_en),
        .cur_pc       (cur_pc),
        .cur_ccr      (cur_ccr),
        .cur_sp       (cur_sp),
        .mem_rdata    (mem_rdata),
        .lat_pc       (lat_pc),
        .lat_ccr      (lat_ccr),
        .lat_sp       (lat_sp),
        .lat_num      (lat_num),
        .new_pc       (new_pc),
        .new_ccr      (new_ccr),
        .new_sp       (new_sp)
    );

    exc_bus_drv #(.WORD_W(WORD_W)) u_bus (
        .state     (state),
        .lat_pc    (lat_pc),
        .lat_ccr   (lat_ccr),
        .lat_sp    (lat_sp),
        .lat_num   (lat_num),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata)
    );

    assign done      = (state == ST_FIN);
    assign busy      = (state != ST_IDLE);
    assign int_block = (state == ST_HOLD) || (state == ST_POST) ||
                       (in_reset_seq && ((state == ST_FETCH) || (state == ST_FIN)));

endmodule

// File: rtl/exc_seq_checker.sv
module exc_seq_checker #(
    parameter int WORD_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              cpu_reset_n,
    input logic              mem_req,
    input logic              mem_ready,
    input logic              mem_we,
    input logic [WORD_W-1:0] mem_addr,
    input logic [WORD_W-1:0] mem_wdata,
    input logic [7:0]        new_ccr,
    input logic              done,
    input logic              busy,
    input logic              int_block
);

    p_hold_access_r9: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ready && cpu_reset_n) |=>
            (mem_req && $stable(mem_addr) && $stable(mem_wdata) && $stable(mem_we)));

    p_abort_r2: assert property (@(posedge clk) disable iff (rst)
        !cpu_reset_n |=> (!mem_req && !done && busy && int_block));

    p_single_done_r10: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_mask_on_done_r6: assert property (@(posedge clk) disable iff (rst)
        done |-> new_ccr[7]);

    p_no_access_on_done_r3: assert property (@(posedge clk) disable iff (rst)
        done |-> !mem_req);

endmodule

bind exc_entry_seq exc_seq_checker #(.WORD_W(WORD_W)) u_exc_seq_checker (
    .clk         (clk),
    .rst         (rst),
    .cpu_reset_n (cpu_reset_n),
    .mem_req     (mem_req),
    .mem_ready   (mem_ready),
    .mem_we      (mem_we),
    .mem_addr    (mem_addr),
    .mem_wdata   (mem_wdata),
    .new_ccr     (new_ccr),
    .done        (done),
    .busy        (busy),
    .int_block   (int_block)
);

// File: tb/test_exc_entry_seq.sv
module test_exc_entry_seq;

    localparam int CLK_PERIOD = 10;

    logic        clk, rst, cpu_reset_n, user_en;
    logic        nmi_req, trap_req, irq_req;
    logic [1:0]  trap_idx;
    logic [3:0]  irq_num;
    logic [31:0] cur_pc, cur_sp;
    logic [7:0]  cur_ccr;
    logic        mem_req, mem_we, mem_ready;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic [31:0] new_pc, new_sp;
    logic [7:0]  new_ccr;
    logic        done, busy, int_block;

    int checks = 0;
    int fails  = 0;
    bit started = 0;

    exc_entry_seq i_exc_entry_seq (
        .clk(clk), .rst(rst), .cpu_reset_n(cpu_reset_n), .user_en(user_en),
        .nmi_req(nmi_req), .trap_req(trap_req), .trap_idx(trap_idx),
        .irq_req(irq_req), .irq_num(irq_num), .cur_pc(cur_pc),
        .cur_ccr(cur_ccr), .cur_sp(cur_sp), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ready(mem_ready), .new_pc(new_pc),
        .new_ccr(new_ccr), .new_sp(new_sp), .done(done), .busy(busy),
        .int_block(int_block)
    );

    initial begin
        clk = 1'b0;
        forever #(CLK_PERIOD/2) clk = ~clk;
    end

    function automatic logic [31:0] vec_word(input logic [31:0] a);
        return 32'h4000_0000 + a * 32'h101;
    endfunction

    task automatic cmp(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // ---------------- memory responder ----------------
    int wcnt = 0;
    int lat  = 0;
    always @(negedge clk) begin
        if (mem_req === 1'b1) begin
            if (wcnt >= lat) begin
                mem_ready = 1'b1;
                wcnt = 0;
                lat = $urandom % 3;
            end else begin
                mem_ready = 1'b0;
                wcnt++;
            end
        end else begin
            mem_ready = 1'b0;
            wcnt = 0;
        end
        mem_rdata = vec_word(mem_addr);
    end

    // ---------------- behavioural reference ----------------
    typedef struct { bit we; logic [31:0] addr; logic [31:0] data; } op_t;
    op_t         q[$];
    bit          m_hold, m_rnq, m_fin, m_post, m_isrst, m_ue;
    logic [31:0] m_pc, m_sp, l_pc, l_sp;
    logic [7:0]  m_ccr, l_ccr;

    always @(posedge clk) begin
        op_t o;
        int  num;
        started = 1;
        if (rst) begin
            m_hold = 1; m_rnq = 0; q.delete(); m_fin = 0; m_post = 0;
            m_isrst = 0; m_pc = 0; m_ccr = 0; m_sp = 0;
        end else begin
            if (!cpu_reset_n) begin
                m_hold = 1; q.delete(); m_fin = 0; m_post = 0;
            end else if (m_hold) begin
                if (!m_rnq) begin
                    m_hold = 0; m_isrst = 1;
                    q.push_back('{0, 32'h0, 32'h0});
                end
            end else if (q.size() != 0) begin
                if (mem_ready) begin
                    o = q.pop_front();
                    if (q.size() == 0) begin
                        m_pc = vec_word(o.addr);
                        if (m_isrst) m_ccr = 8'hC0;
                        else begin
                            m_ccr = l_ccr | (m_ue ? 8'h80 : 8'hC0);
                            m_sp  = l_sp - 8;
                        end
                        m_fin = 1;
                    end
                end
            end else if (m_fin) begin
                m_fin = 0; m_post = m_isrst;
            end else if (m_post) begin
                m_post = 0;
            end else if (nmi_req || trap_req || irq_req) begin
                num = nmi_req ? 7 : trap_req ? 8 + int'(trap_idx) : int'(irq_num);
                m_isrst = 0; m_ue = user_en;
                l_pc = cur_pc; l_sp = cur_sp; l_ccr = cur_ccr;
                q.push_back('{1, l_sp - 4, l_pc});
                q.push_back('{1, l_sp - 8, {l_ccr, 24'h0}});
                q.push_back('{0, 32'(num * 4), 32'h0});
            end
            m_rnq = cpu_reset_n;
        end
    end

    // ---------------- per-cycle comparison ----------------
    always @(negedge clk) begin
        if (started) begin
            bit e_req;
            e_req = (q.size() != 0);
            cmp("R9", "mem_req", 32'(mem_req), 32'(e_req));
            if (e_req) begin
                cmp("R7", "mem_addr", mem_addr, q[0].addr);
                cmp("R5", "mem_we", 32'(mem_we), 32'(q[0].we));
                if (q[0].we) cmp("R5", "mem_wdata", mem_wdata, q[0].data);
            end
            cmp("R10", "done", 32'(done), 32'(m_fin));
            cmp("R10", "busy", 32'(busy), 32'(m_hold || e_req || m_fin || m_post));
            cmp("R4", "int_block", 32'(int_block),
                32'(m_hold || m_post || (m_isrst && (e_req || m_fin))));
            cmp("R3", "new_pc", new_pc, m_pc);
            cmp("R6", "new_ccr", 32'(new_ccr), 32'(m_ccr));
            cmp("R5", "new_sp", new_sp, m_sp);
        end
    end

    // ---------------- stimulus ----------------
    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    endtask

    task automatic wait_done(input string tag);
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (done) return;
        end
        cmp(tag, "done timeout", 32'd0, 32'd1);
    endtask

    task automatic pulse(input bit n, input bit t, input bit r);
        @(negedge clk);
        nmi_req = n; trap_req = t; irq_req = r;
        @(negedge clk);
        nmi_req = 0; trap_req = 0; irq_req = 0;
    endtask

    initial begin
        rst = 1; cpu_reset_n = 1; user_en = 1;
        nmi_req = 0; trap_req = 0; irq_req = 0; trap_idx = 0; irq_num = 0;
        cur_pc = 0; cur_sp = 0; cur_ccr = 0;
        repeat (3) @(negedge clk);
        cmp("R1", "mem_req in reset", 32'(mem_req), 32'd0);
        cmp("R1", "int_block in reset", 32'(int_block), 32'd1);
        cmp("R1", "new_pc in reset", new_pc, 32'd0);
        rst = 0;
        @(negedge clk);
        cmp("R1", "busy after reset", 32'(busy), 32'd1);

        // reset sequence from release of rst
        wait_done("R3");
        cmp("R3", "reset pc", new_pc, vec_word(32'h0));
        cmp("R3", "reset ccr", 32'(new_ccr), 32'hC0);
        @(negedge clk);
        cmp("R4", "post-reset block", 32'(int_block), 32'd1);
        irq_req = 1; irq_num = 3;
        @(negedge clk);
        irq_req = 0;
        cmp("R4", "request during block dropped", 32'(busy), 32'd0);
        @(negedge clk);
        cmp("R4", "no access after dropped request", 32'(mem_req), 32'd0);

        // maskable interrupt, user_en = 1
        cur_pc = 32'h0000_1234; cur_sp = 32'h0000_2000; cur_ccr = 8'h05;
        user_en = 1; irq_num = 9;
        pulse(0, 0, 1);
        wait_done("R6");
        cmp("R6", "ccr I only", 32'(new_ccr), 32'h85);
        cmp("R5", "sp after pushes", new_sp, 32'h0000_1FF8);
        cmp("R7", "irq vector", new_pc, vec_word(32'h24));
        @(negedge clk);

        // trap index 3, user_en = 0
        cur_ccr = 8'h00; user_en = 0; trap_idx = 3; cur_sp = 32'h0000_3000;
        pulse(0, 1, 0);
        wait_done("R6");
        cmp("R6", "ccr I and UI", 32'(new_ccr), 32'hC0);
        cmp("R7", "trap vector", new_pc, vec_word(32'h2C));
        @(negedge clk);

        // priority
        trap_idx = 1; irq_num = 2;
        @(negedge clk);
        nmi_req = 1; trap_req = 1; irq_req = 1;
        @(negedge clk);
        nmi_req = 0; trap_req = 0; irq_req = 0;
        for (int i = 0; i < 20 && !(mem_req && !mem_we); i++) @(negedge clk);
        cmp("R8", "nmi wins vector address", mem_addr, 32'h1C);
        wait_done("R8");
        @(negedge clk);

        // request while busy is dropped
        pulse(0, 0, 1);
        nmi_req = 1;
        @(negedge clk);
        nmi_req = 0;
        wait_done("R10");
        @(negedge clk);
        @(negedge clk);
        cmp("R10", "busy request dropped", 32'(busy), 32'd0);

        // abort in the middle of a push
        pulse(0, 0, 1);
        for (int i = 0; i < 10 && !(mem_req && mem_we); i++) @(negedge clk);
        cpu_reset_n = 0;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            cmp("R2", "abort drops access", 32'(mem_req), 32'd0);
            cmp("R2", "abort blocks", 32'(int_block), 32'd1);
            cmp("R3", "no start while low", 32'(done), 32'd0);
        end
        cpu_reset_n = 1;
        wait_done("R3");
        cmp("R3", "reset pc after abort", new_pc, vec_word(32'h0));
        @(negedge clk);
        @(negedge clk);

        // random traffic
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            nmi_req  = ($urandom % 23) == 0;
            trap_req = ($urandom % 17) == 0;
            irq_req  = ($urandom % 7) == 0;
            trap_idx = 2'($urandom);
            irq_num  = 4'($urandom);
            user_en  = 1'($urandom);
            cur_pc   = $urandom;
            cur_sp   = $urandom & 32'hFFFF_FFFC;
            cur_ccr  = 8'($urandom);
            if (cpu_reset_n) cpu_reset_n = ($urandom % 150) != 0;
            else cpu_reset_n = ($urandom % 3) == 0;
        end
        @(negedge clk);
        nmi_req = 0; trap_req = 0; irq_req = 0; cpu_reset_n = 1;
        repeat (20) @(negedge clk);
        finish_run();
    end

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

endmodule